// File: doc/BRIEF.md
# Wildcard DNA Score-Only Alignment Array

This block scores how well a streamed DNA query aligns against a stored reference. The reference has up to `N` positions, and each position is held in its own processing cell. Each reference position is a set of acceptable bases rather than a single symbol. A position can accept any combination of A, C, G and T, so ambiguity codes and "any base" positions need no extra logic.

The query arrives one 2-bit base per clock on a valid/last stream. The cells form a linear systolic chain. Each cell evaluates one cell of the dynamic-programming matrix per clock and hands the query base, its flags and its cell score to the right-hand neighbour one cycle later.

A controller latches the alignment mode (local or global) and the gap penalty when the first base of a query is accepted. It generates the left boundary column and collects the result from the last cell. It raises `done` for one cycle with the final score. Only the goodness-of-match score is produced; no alignment path is recorded.

The controller is a three-state machine:
- **IDLE**: waiting for a first base. Taking a base that is not marked last moves it to **RUN**. Taking a single-base query (first and last together) moves it straight to **FLUSH**.
- **RUN**: accepting bases. Taking the base marked last moves it to **FLUSH**.
- **FLUSH**: the last base travels down the chain and query input is ignored. When the last base leaves the final cell, the state returns to **IDLE** and `done` pulses.

Top module: `wildcard_align_array`

## Requirements
- R1: Reference flags use bit 0 for A, bit 1 for C, bit 2 for G and bit 3 for T. Query codes are 0=A, 1=C, 2=G, 3=T. A cell scores +1 when the flag bit selected by the query code is set, and -10 otherwise; an all-zero flag set never matches.
- R2: Each insertion or deletion adds the gap value held in a configuration register. That register resets to -10 and is written with `cfg_gap_we`/`cfg_gap` (11-bit two's complement).
- R3: With `mode_local`=1 at query start, every cell is clamped at a minimum of 0, and the reported score is the largest cell value anywhere in the matrix.
- R4: With `mode_local`=0 at query start, no clamp applies. Row 0 of column j holds j×gap, column 0 of row i holds i×gap, and the reported score is the final reference position's cell for the last query base.
- R5: All score arithmetic saturates at -1000 and +1000 and never wraps.
- R6: `done` is high for exactly one cycle. It rises at the Nth rising edge after the edge that accepts the base marked last.
- R7: After reset `score` is 0 and `done` is 0. `score` changes only in a cycle where `done` is high, and holds between results.
- R8: Mode and gap are sampled with the first base. Changes to `mode_local` or writes to the gap register during a query do not affect that query's score.
- R9: Bases offered while the controller is in FLUSH are ignored. They neither start a query nor alter the result.
- R10: Cycles with `q_valid` low are bubbles and do not count as query bases.
- R11: The controller moves IDLE→RUN on a first base, IDLE→FLUSH on a single-base query, RUN→FLUSH on the last base, and FLUSH→IDLE when the last base leaves the final cell. A new query may start in the cycle after `done`.
- R12: A write with `ref_we` stores `ref_flags` into reference position `ref_addr`. Position 0 is the cell that first sees each query base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_we | input | 1 | Reference position write enable |
| ref_addr | input | AW = clog2(N) | Reference position to write |
| ref_flags | input | 4 | Accepted-base flags {T,G,C,A} |
| cfg_gap_we | input | 1 | Gap register write enable |
| cfg_gap | input | 11 | Gap value, two's complement |
| mode_local | input | 1 | 1 = local alignment, 0 = global |
| q_valid | input | 1 | Query base valid |
| q_base | input | 2 | Query base code |
| q_last | input | 1 | Marks the final query base |
| score | output | 11 | Final score, two's complement |
| done | output | 1 | One-cycle result strobe |

## Verification
The hardest situations to reach from the ports are those where saturation and the mid-query sampling rules matter. The bench drives a 120-base global query against an all-empty reference, which pushes the scores to the -1000 rail. It then runs a long query with a positive gap, which pushes them to the +1000 rail. During other queries it toggles the mode input and rewrites the gap after the first base, and it floods the query input with bases, including last flags, throughout the flush window. Every one of these runs is scored against a behavioural matrix model, and `done` and `score` are compared against that model on every clock.

// File: rtl/wdp_pkg.sv
package wdp_pkg;
    localparam int SW   = 11;
    localparam int SMAX = 1000;
    localparam int SMIN = -1000;

    typedef logic signed [SW-1:0] score_t;

    localparam score_t MATCH_PTS = 11'sd1;
    localparam score_t MISS_PTS  = -11'sd10;
    localparam score_t GAP_DEF   = -11'sd10;

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FLUSH} ctl_state_e;

    function automatic score_t sat_add(score_t a, score_t b);
        logic signed [SW:0] s;
        s = {a[SW-1], a} + {b[SW-1], b};
        if (s > 12'sd1000)
            return score_t'(SMAX);
        else if (s < -12'sd1000)
            return score_t'(SMIN);
        else
            return s[SW-1:0];
    endfunction

    function automatic score_t sat_mul(int k, score_t g);
        int p;
        p = k * int'(g);
        if (p > SMAX)
            return score_t'(SMAX);
        else if (p < SMIN)
            return score_t'(SMIN);
        else
            return score_t'(p);
    endfunction

    function automatic score_t max2(score_t a, score_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/aln_cell.sv
module aln_cell
    import wdp_pkg::*;
#(
    parameter int POS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_en,
    input  logic [3:0] ld_flags,
    input  logic       in_v,
    input  logic       in_f,
    input  logic       in_l,
    input  logic [1:0] in_q,
    input  score_t     in_h,
    input  score_t     in_best,
    input  logic       run_local,
    input  score_t     run_gap,
    output logic       out_v,
    output logic       out_f,
    output logic       out_l,
    output logic [1:0] out_q,
    output score_t     out_h,
    output score_t     out_best
);
    logic [3:0] flags_r;
    score_t     diag_r;
    score_t     up_w, dg_w, sc_w, c_d, c_u, c_l, h_w;

    always_comb begin
        up_w = in_f ? (run_local ? score_t'(0) : sat_mul(POS, run_gap)) : out_h;
        dg_w = in_f ? (run_local ? score_t'(0) : sat_mul(POS - 1, run_gap)) : diag_r;
        sc_w = flags_r[in_q] ? MATCH_PTS : MISS_PTS;
        c_d  = sat_add(dg_w, sc_w);
        c_u  = sat_add(up_w, run_gap);
        c_l  = sat_add(in_h, run_gap);
        h_w  = max2(max2(c_d, c_u), c_l);
        if (run_local)
            h_w = max2(h_w, score_t'(0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_r  <= '0;
            diag_r   <= '0;
            out_v    <= 1'b0;
            out_f    <= 1'b0;
            out_l    <= 1'b0;
            out_q    <= '0;
            out_h    <= '0;
            out_best <= '0;
        end else begin
            if (ld_en)
                flags_r <= ld_flags;
            out_v <= in_v;
            if (in_v) begin
                out_f    <= in_f;
                out_l    <= in_l;
                out_q    <= in_q;
                out_h    <= h_w;
                diag_r   <= in_h;
                out_best <= max2(in_best, h_w);
            end
        end
    end

    // R5
    cell_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_v |-> (out_h >= -11'sd1000 && out_h <= 11'sd1000));
endmodule

// File: rtl/aln_ctrl.sv
module aln_ctrl
    import wdp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  score_t     cfg_val,
    input  logic       mode_in,
    input  logic       q_valid,
    input  logic       q_last,
    output logic       head_v,
    output logic       head_f,
    output score_t     head_h,
    output logic       run_local,
    output score_t     run_gap,
    input  logic       tail_v,
    input  logic       tail_f,
    input  logic       tail_l,
    input  score_t     tail_h,
    input  score_t     tail_best,
    output score_t     score,
    output logic       done
);
    ctl_state_e st, st_nx;
    score_t     gap_cfg, gap_q, bprev, tbest, best_w;
    logic       mode_q;

    assign head_v    = q_valid && (st != S_FLUSH);
    assign head_f    = head_v && (st == S_IDLE);
    assign run_local = (st == S_IDLE) ? mode_in : mode_q;
    assign run_gap   = (st == S_IDLE) ? gap_cfg : gap_q;
    assign best_w    = tail_f ? tail_best : max2(tbest, tail_best);

    always_comb begin
        if (run_local)
            head_h = '0;
        else if (head_f)
            head_h = run_gap;
        else
            head_h = sat_add(bprev, run_gap);
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (head_v) st_nx = q_last ? S_FLUSH : S_RUN;
            S_RUN:   if (head_v && q_last) st_nx = S_FLUSH;
            S_FLUSH: if (tail_v && tail_l) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= S_IDLE;
        else
            st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cfg <= GAP_DEF;
            gap_q   <= GAP_DEF;
            mode_q  <= 1'b0;
            bprev   <= '0;
            tbest   <= '0;
        end else begin
            if (cfg_we)
                gap_cfg <= cfg_val;
            if (head_f) begin
                gap_q  <= gap_cfg;
                mode_q <= mode_in;
            end
            if (head_v)
                bprev <= head_h;
            if (tail_v)
                tbest <= best_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            score <= '0;
            done  <= 1'b0;
        end else begin
            done <= tail_v && tail_l;
            if (tail_v && tail_l)
                score <= mode_q ? best_w : tail_h;
        end
    end

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    score_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> score == $past(score));
    // R3
    local_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q) |-> score >= 0);
    // R11
    done_from_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(st) == S_FLUSH && st == S_IDLE));
endmodule

// File: rtl/wildcard_align_array.sv
module wildcard_align_array
    import wdp_pkg::*;
#(
    parameter int N = 8,
    localparam int AW = $clog2(N > 1 ? N : 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_we,
    input  logic [AW-1:0] ref_addr,
    input  logic [3:0]    ref_flags,
    input  logic          cfg_gap_we,
    input  logic [SW-1:0] cfg_gap,
    input  logic          mode_local,
    input  logic          q_valid,
    input  logic [1:0]    q_base,
    input  logic          q_last,
    output logic [SW-1:0] score,
    output logic          done
);
    logic       v_chain [0:N];
    logic       f_chain [0:N];
    logic       l_chain [0:N];
    logic [1:0] q_chain [0:N];
    score_t     h_chain [0:N];
    score_t     b_chain [0:N];
    logic       run_local;
    score_t     run_gap;
    score_t     score_w;
    logic [1:0] q_tail_unused;

    assign l_chain[0]    = q_last;
    assign q_chain[0]    = q_base;
    assign b_chain[0]    = '0;
    assign q_tail_unused = q_chain[N];
    assign score         = score_w;

    aln_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_gap_we),
        .cfg_val   (score_t'(cfg_gap)),
        .mode_in   (mode_local),
        .q_valid   (q_valid),
        .q_last    (q_last),
        .head_v    (v_chain[0]),
        .head_f    (f_chain[0]),
        .head_h    (h_chain[0]),
        .run_local (run_local),
        .run_gap   (run_gap),
        .tail_v    (v_chain[N]),
        .tail_f    (f_chain[N]),
        .tail_l    (l_chain[N]),
        .tail_h    (h_chain[N]),
        .tail_best (b_chain[N]),
        .score     (score_w),
        .done      (done)
    );

    for (genvar g = 0; g < N; g++) begin : g_cell
        aln_cell #(.POS(g + 1)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_en     (ref_we && (ref_addr == AW'(g))),
            .ld_flags  (ref_flags),
            .in_v      (v_chain[g]),
            .in_f      (f_chain[g]),
            .in_l      (l_chain[g]),
            .in_q      (q_chain[g]),
            .in_h      (h_chain[g]),
            .in_best   (b_chain[g]),
            .run_local (run_local),
            .run_gap   (run_gap),
            .out_v     (v_chain[g+1]),
            .out_f     (f_chain[g+1]),
            .out_l     (l_chain[g+1]),
            .out_q     (q_chain[g+1]),
            .out_h     (h_chain[g+1]),
            .out_best  (b_chain[g+1])
        );
    end

    // R6
    done_after_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(v_chain[N] && l_chain[N]));
endmodule

// File: tb/wildcard_align_array_tb.sv
`timescale 1ns/1ps
module wildcard_align_array_tb;
    localparam int N  = 8;
    localparam int AW = $clog2(N > 1 ? N : 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_we = 1'b0;
    logic [AW-1:0] ref_addr = '0;
    logic [3:0]    ref_flags = '0;
    logic          cfg_gap_we = 1'b0;
    logic [10:0]   cfg_gap = '0;
    logic          mode_local = 1'b0;
    logic          q_valid = 1'b0;
    logic [1:0]    q_base = '0;
    logic          q_last = 1'b0;
    logic [10:0]   score;
    logic          done;

    always #4 clk = ~clk;

    wildcard_align_array #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_we(ref_we), .ref_addr(ref_addr),
        .ref_flags(ref_flags), .cfg_gap_we(cfg_gap_we), .cfg_gap(cfg_gap),
        .mode_local(mode_local), .q_valid(q_valid), .q_base(q_base),
        .q_last(q_last), .score(score), .done(done)
    );

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    int    due_cyc = -1;
    int    due_score = 0;
    int    exp_score = 0;
    int    gap_now = -10;
    int    refs [N];
    string score_tag = "R7";
    bit    finished = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Reference model step: compare both outputs on every clock.
    task automatic tick();
        bit exp_done;
        @(negedge clk);
        cyc++;
        exp_done = (cyc == due_cyc);
        if (exp_done)
            exp_score = due_score;
        chk("R6", int'(done), int'(exp_done));
        chk(exp_done ? score_tag : "R7", int'($signed(score)), exp_score);
    endtask

    function automatic int sat(input int x);
        return (x > 1000) ? 1000 : ((x < -1000) ? -1000 : x);
    endfunction

    function automatic int model(input bit loc, input int g, input int qs[$]);
        int prev[];
        int cur[];
        int best;
        int s, h;
        prev = new[N + 1];
        cur  = new[N + 1];
        best = 0;
        for (int j = 0; j <= N; j++)
            prev[j] = loc ? 0 : sat(j * g);
        for (int i = 1; i <= qs.size(); i++) begin
            cur[0] = loc ? 0 : sat(i * g);
            for (int j = 1; j <= N; j++) begin
                s = ((refs[j-1] >> qs[i-1]) & 1) ? 1 : -10;
                h = sat(prev[j-1] + s);
                if (sat(prev[j] + g) > h) h = sat(prev[j] + g);
                if (sat(cur[j-1] + g) > h) h = sat(cur[j-1] + g);
                if (loc && h < 0) h = 0;
                if (h > best) best = h;
                cur[j] = h;
            end
            for (int j = 0; j <= N; j++)
                prev[j] = cur[j];
        end
        return loc ? best : prev[N];
    endfunction

    task automatic load_ref(input int pos, input int f);
        tick();
        ref_we    = 1'b1;
        ref_addr  = AW'(pos);
        ref_flags = 4'(f);
        refs[pos] = f;
        tick();
        ref_we = 1'b0;
    endtask

    task automatic set_gap(input int g);
        tick();
        cfg_gap_we = 1'b1;
        cfg_gap    = 11'(g);
        gap_now    = g;
        tick();
        cfg_gap_we = 1'b0;
    endtask

    task automatic send_query(input bit loc, input int qs[$], input bit bub,
                              input bit disturb, input bit noise, input string tag);
        int m;
        int expv;
        m    = qs.size();
        expv = model(loc, gap_now, qs);
        for (int i = 0; i < m; i++) begin
            if (bub && (i % 2 == 1)) begin
                tick();
                q_valid    = 1'b0;
                cfg_gap_we = 1'b0;
            end
            tick();
            q_valid    = 1'b1;
            q_base     = 2'(qs[i]);
            q_last     = (i == m - 1);
            mode_local = (disturb && i > 0) ? !loc : loc;
            cfg_gap_we = disturb && (i == 1);
            cfg_gap    = 11'(gap_now + 7);
            if (i == m - 1) begin
                due_cyc   = cyc + N + 1;
                due_score = expv;
                score_tag = tag;
            end
        end
        if (disturb && m > 1)
            gap_now = gap_now + 7;
        for (int k = 0; k < N; k++) begin
            tick();
            cfg_gap_we = 1'b0;
            if (noise) begin
                q_valid    = 1'b1;
                q_base     = 2'(k);
                q_last     = k[0];
                mode_local = !loc;
            end else begin
                q_valid = 1'b0;
                q_last  = 1'b0;
            end
        end
        tick();
        q_valid = 1'b0;
        q_last  = 1'b0;
        tick();
    endtask

    initial begin
        int qs[$];
        for (int p = 0; p < N; p++) refs[p] = 0;
        repeat (3) tick();
        // R7: reset state is checked by the ticks above (done=0, score=0)
        rst_n = 1'b1;
        tick();

        // R12 / R1: exact single-base reference ACGTACGT
        for (int p = 0; p < N; p++) load_ref(p, 1 << (p % 4));
        qs = {};
        for (int p = 0; p < N; p++) qs.push_back(p % 4);
        send_query(1'b1, qs, 1'b0, 1'b0, 1'b0, "R3");
        // R4 / R2: global with default gap of -10
        send_query(1'b0, qs, 1'b0, 1'b0, 1'b0, "R2");
        qs = {3, 0, 1, 2, 3, 0, 1, 2, 2, 1};
        send_query(1'b0, qs, 1'b0, 1'b0, 1'b0, "R4");

        // R1 / R12: wildcard flag sets, including empty and full
        load_ref(0, 4'b0011); load_ref(1, 4'b1111); load_ref(2, 4'b0000);
        load_ref(3, 4'b1000); load_ref(4, 4'b0101); load_ref(5, 4'b0110);
        load_ref(6, 4'b1111); load_ref(7, 4'b0001);
        qs = {1, 2, 0, 3, 2, 1, 3, 0, 0, 1};
        send_query(1'b1, qs, 1'b0, 1'b0, 1'b0, "R1");
        send_query(1'b0, qs, 1'b0, 1'b0, 1'b0, "R12");

        // R5: empty reference, long global query rails at -1000
        for (int p = 0; p < N; p++) load_ref(p, 0);
        qs = {};
        for (int i = 0; i < 120; i++) qs.push_back(i % 4);
        send_query(1'b0, qs, 1'b0, 1'b0, 1'b0, "R5");
        send_query(1'b1, qs, 1'b0, 1'b0, 1'b0, "R3");

        // R5 / R2: positive gap pushes global scores to +1000
        set_gap(10);
        qs = {};
        for (int i = 0; i < 110; i++) qs.push_back((i * 3) % 4);
        send_query(1'b0, qs, 1'b0, 1'b0, 1'b0, "R5");

        // R10: bubbles between bases, local, gap -3
        set_gap(-3);
        for (int p = 0; p < N; p++) load_ref(p, 1 << ((p * 3) % 4));
        qs = {0, 3, 2, 1, 0, 3, 2, 1, 1, 2, 3};
        send_query(1'b1, qs, 1'b1, 1'b0, 1'b0, "R10");
        send_query(1'b0, qs, 1'b1, 1'b0, 1'b0, "R10");

        // R6 / R11: single-base query (IDLE straight to FLUSH)
        qs = {0};
        send_query(1'b0, qs, 1'b0, 1'b0, 1'b0, "R11");
        qs = {3};
        send_query(1'b1, qs, 1'b0, 1'b0, 1'b0, "R6");

        // R8: mode toggled and gap rewritten mid-query
        qs = {1, 0, 3, 2, 0, 0, 1, 3, 2};
        send_query(1'b0, qs, 1'b0, 1'b1, 1'b0, "R8");
        send_query(1'b1, qs, 1'b0, 1'b1, 1'b0, "R8");

        // R9: input flooded during flush, then a back-to-back query (R11)
        qs = {2, 2, 1, 0, 3, 3};
        send_query(1'b1, qs, 1'b0, 1'b0, 1'b1, "R9");
        qs = {0, 1, 2, 3, 3, 2, 1, 0};
        send_query(1'b0, qs, 1'b0, 1'b0, 1'b1, "R9");
        send_query(1'b0, qs, 1'b0, 1'b0, 1'b0, "R11");

        repeat (4) tick();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R6: actual=hung expected=finished (watchdog)");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule